// File: doc/BRIEF.md
# Host Port Initialization and DMA Byte Sequencer

This block holds the control state for the host side of a byte-wide parallel port. The port carries a 24-bit word as one, two or three bytes. The host writes a control word made of an initialization command bit, a transmit request enable, a receive request enable and a 2-bit mode field. The command bit starts a one-shot initialization. That initialization prepares the transfer channel, or channels, chosen by the request enables, and it preloads the byte address counter. The block then clears the command bit by itself.

Mode 00 is interrupt mode. The three non-zero modes select DMA with a word size of three, two or one bytes. In DMA mode each acknowledge strobe moves the byte address one step toward the low byte. After the low byte, the counter reloads from the mode field and the finished word updates the channel flags. The byte data registers and the interrupt vector logic sit outside this block.

Top module: `hostport_init_seq`

## Requirements
- R1: After the asynchronous reset every output is 0: init bit, byte address, the four channel flags and the error strobe.
- R2: A control write with the init bit set makes `init_flag` read 1 in the cycle after the write. The command runs at the next edge, and `init_flag` reads 0 from then on.
- R3: `soft_rst`, `port_rst` and `stop_req` each clear the init bit. A control write made in the same cycle as any of them never runs its command.
- R4: An initialization with both request enables at 0 leaves all four flags unchanged and loads the byte address from the mode field.
- R5: An initialization with the receive enable set (host-to-DSP direction) clears `dsp_rx_full` and sets `host_tx_empty`.
- R6: An initialization with the transmit enable set (DSP-to-host direction) sets `dsp_tx_empty` and clears `host_rx_full`.
- R7: In interrupt mode (mode 00) both enables may be set together. One initialization then prepares both directions and loads the byte address with 00.
- R8: In DMA mode an initialization loads the byte address with the mode value. Mode 01 is a three-byte word (addresses 01, 10, 11), mode 10 is a two-byte word (10, 11) and mode 11 is a one-byte word (11). Address 11 is the low byte.
- R9: In DMA mode each `dma_ack` pulse adds one to the byte address. An ack at address 11 reloads the address from the mode field.
- R10: In interrupt mode `dma_ack` changes neither the byte address nor the flags.
- R11: An initialization in DMA mode with both enables set leaves the flags unchanged, still loads the address, and raises `init_err` for exactly one cycle.
- R12: `soft_rst` or `port_rst` in the same cycle as an init write returns all flags and the byte address to their reset values.
- R13: The ack that ends a DMA word sets `dsp_rx_full` and clears `host_tx_empty` when the receive enable is set. It sets `host_rx_full` and clears `dsp_tx_empty` when the transmit enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| port_rst | input | 1 | Synchronous reset of this port only |
| stop_req | input | 1 | Stop condition; clears the init bit |
| ctl_wr | input | 1 | Host control-word write strobe |
| ctl_init | input | 1 | Init command bit of the written word |
| ctl_treq | input | 1 | Transmit request enable of the written word |
| ctl_rreq | input | 1 | Receive request enable of the written word |
| ctl_mode | input | ADDR_W | Mode field of the written word (0 = interrupt) |
| dma_ack | input | 1 | DMA acknowledge strobe, one per byte |
| init_flag | output | 1 | Readback of the init command bit |
| byte_addr | output | ADDR_W | Current byte address |
| dsp_rx_full | output | 1 | DSP-side receive-full flag |
| dsp_tx_empty | output | 1 | DSP-side transmit-empty flag |
| host_rx_full | output | 1 | Host-side receive-full flag |
| host_tx_empty | output | 1 | Host-side transmit-empty flag |
| init_err | output | 1 | One-cycle strobe for an illegal initialization |

## Verification
The bench builds the block with the default `ADDR_W` of 2. This gives the three DMA word sizes plus interrupt mode, and it puts the reload from the low byte inside a few acks. With that width every mode value can be driven directly: the full three-byte walk, the two- and one-byte reloads, and the illegal both-enables case in DMA mode. Directed sequences first move the flags away from their reset values through finished words, then check that an initialization restores them. This shows both the set and the clear actions of each direction.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef struct packed {
    logic dsp_rx_full;
    logic dsp_tx_empty;
    logic host_rx_full;
    logic host_tx_empty;
  } chan_flags_t;

  localparam chan_flags_t FLAGS_RST = '{default: 1'b0};
endpackage

// File: rtl/hpi_ctl_regs.sv
module hpi_ctl_regs #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stop_req,
  input  logic              ctl_wr,
  input  logic              ctl_init,
  input  logic              ctl_treq,
  input  logic              ctl_rreq,
  input  logic [ADDR_W-1:0] ctl_mode,
  output logic              init_q,
  output logic              treq_q,
  output logic              rreq_q,
  output logic [ADDR_W-1:0] mode_q,
  output logic              exec
);
  logic              init_n, treq_n, rreq_n;
  logic [ADDR_W-1:0] mode_n;
  logic              cfg_en;

  // command runs in the cycle the init bit is held
  assign exec   = init_q;
  assign cfg_en = clr | ctl_wr;

  always_comb begin
    treq_n = treq_q;
    rreq_n = rreq_q;
    mode_n = mode_q;
    if (clr) begin
      treq_n = 1'b0;
      rreq_n = 1'b0;
      mode_n = '0;
    end else if (ctl_wr) begin
      treq_n = ctl_treq;
      rreq_n = ctl_rreq;
      mode_n = ctl_mode;
    end
    // init lasts one cycle; any reset or stop drops it
    init_n = ctl_wr & ctl_init & ~clr & ~stop_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      treq_q <= 1'b0;
      rreq_q <= 1'b0;
      mode_q <= '0;
    end else begin
      init_q <= init_n;
      if (cfg_en) begin
        treq_q <= treq_n;
        rreq_q <= rreq_n;
        mode_q <= mode_n;
      end
    end
  end

  assert_init_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !(ctl_wr && ctl_init)) |=> !init_q);

  assert_stop_clears_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || stop_req) |=> !init_q);
endmodule

// File: rtl/hpi_byte_cnt.sv
module hpi_byte_cnt #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              exec,
  input  logic [ADDR_W-1:0] mode,
  input  logic              ack,
  output logic [ADDR_W-1:0] cnt,
  output logic              word_done
);
  localparam logic [ADDR_W-1:0] LOW_ADDR = {ADDR_W{1'b1}};

  logic              dma_mode;
  logic              step;
  logic              cnt_en;
  logic [ADDR_W-1:0] cnt_n;

  assign dma_mode  = |mode;
  assign step      = ack & dma_mode & ~exec & ~clr;
  assign word_done = step & (cnt == LOW_ADDR);
  assign cnt_en    = clr | exec | step;

  always_comb begin
    if (clr)            cnt_n = '0;
    else if (exec)      cnt_n = mode;
    else if (word_done) cnt_n = mode;
    else                cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_n;
  end

  assert_init_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !clr) |=> (cnt == $past(mode)));

  assert_int_ack_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode && !exec && !clr) |=> $stable(cnt));

  assert_ack_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && dma_mode && !exec && !clr && cnt != LOW_ADDR)
      |=> (cnt == ADDR_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/hpi_chan_flags.sv
module hpi_chan_flags
  import hpi_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              exec,
  input  logic              treq,
  input  logic              rreq,
  input  logic [ADDR_W-1:0] mode,
  input  logic              word_done,
  output chan_flags_t       flags,
  output logic              err
);
  chan_flags_t flags_n;
  logic        illegal;
  logic        flg_en;
  logic        err_n;

  assign illegal = (|mode) & treq & rreq;
  assign flg_en  = clr | exec | word_done;
  assign err_n   = exec & illegal & ~clr;

  always_comb begin
    flags_n = flags;
    if (clr) begin
      flags_n = FLAGS_RST;
    end else if (exec) begin
      if (!illegal) begin
        if (rreq) begin
          flags_n.dsp_rx_full   = 1'b0;
          flags_n.host_tx_empty = 1'b1;
        end
        if (treq) begin
          flags_n.dsp_tx_empty  = 1'b1;
          flags_n.host_rx_full  = 1'b0;
        end
      end
    end else if (word_done) begin
      if (rreq) begin
        flags_n.dsp_rx_full   = 1'b1;
        flags_n.host_tx_empty = 1'b0;
      end
      if (treq) begin
        flags_n.host_rx_full  = 1'b1;
        flags_n.dsp_tx_empty  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= FLAGS_RST;
      err   <= 1'b0;
    end else begin
      err <= err_n;
      if (flg_en) flags <= flags_n;
    end
  end

  assert_illegal_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && illegal && !clr) |=> ($stable(flags) && err));

  assert_rx_prep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && rreq && !illegal && !clr) |=> (!flags.dsp_rx_full && flags.host_tx_empty));

  assert_tx_prep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && treq && !illegal && !clr) |=> (flags.dsp_tx_empty && !flags.host_rx_full));

  assert_reset_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == FLAGS_RST && !err));
endmodule

// File: rtl/hostport_init_seq.sv
module hostport_init_seq
  import hpi_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              port_rst,
  input  logic              stop_req,
  input  logic              ctl_wr,
  input  logic              ctl_init,
  input  logic              ctl_treq,
  input  logic              ctl_rreq,
  input  logic [ADDR_W-1:0] ctl_mode,
  input  logic              dma_ack,
  output logic              init_flag,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              dsp_rx_full,
  output logic              dsp_tx_empty,
  output logic              host_rx_full,
  output logic              host_tx_empty,
  output logic              init_err
);
  logic              clr;
  logic              treq_q, rreq_q, exec, word_done;
  logic [ADDR_W-1:0] mode_q;
  chan_flags_t       flags;

  assign clr = soft_rst | port_rst;

  hpi_ctl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stop_req(stop_req),
    .ctl_wr(ctl_wr), .ctl_init(ctl_init), .ctl_treq(ctl_treq),
    .ctl_rreq(ctl_rreq), .ctl_mode(ctl_mode),
    .init_q(init_flag), .treq_q(treq_q), .rreq_q(rreq_q),
    .mode_q(mode_q), .exec(exec)
  );

  hpi_byte_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .exec(exec), .mode(mode_q),
    .ack(dma_ack), .cnt(byte_addr), .word_done(word_done)
  );

  hpi_chan_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(clr), .exec(exec), .treq(treq_q),
    .rreq(rreq_q), .mode(mode_q), .word_done(word_done),
    .flags(flags), .err(init_err)
  );

  assign dsp_rx_full   = flags.dsp_rx_full;
  assign dsp_tx_empty  = flags.dsp_tx_empty;
  assign host_rx_full  = flags.host_rx_full;
  assign host_tx_empty = flags.host_tx_empty;
endmodule

// File: tb/hostport_init_seq_bench.sv
module hostport_init_seq_bench;
  localparam int ADDR_W = 2;

  logic clk = 1'b0;
  logic rst_n, soft_rst, port_rst, stop_req;
  logic ctl_wr, ctl_init, ctl_treq, ctl_rreq, dma_ack;
  logic [ADDR_W-1:0] ctl_mode;
  logic init_flag, dsp_rx_full, dsp_tx_empty, host_rx_full, host_tx_empty, init_err;
  logic [ADDR_W-1:0] byte_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  hostport_init_seq #(.ADDR_W(ADDR_W)) u_hostport_init_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .port_rst(port_rst),
    .stop_req(stop_req), .ctl_wr(ctl_wr), .ctl_init(ctl_init),
    .ctl_treq(ctl_treq), .ctl_rreq(ctl_rreq), .ctl_mode(ctl_mode),
    .dma_ack(dma_ack), .init_flag(init_flag), .byte_addr(byte_addr),
    .dsp_rx_full(dsp_rx_full), .dsp_tx_empty(dsp_tx_empty),
    .host_rx_full(host_rx_full), .host_tx_empty(host_tx_empty),
    .init_err(init_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flags packed as {dsp_rx_full, dsp_tx_empty, host_rx_full, host_tx_empty}
  function automatic logic [31:0] flg();
    return {28'd0, dsp_rx_full, dsp_tx_empty, host_rx_full, host_tx_empty};
  endfunction

  task automatic wr(input logic i, input logic t, input logic r, input logic [1:0] m);
    ctl_wr = 1'b1; ctl_init = i; ctl_treq = t; ctl_rreq = r; ctl_mode = m;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_init = 1'b0;
  endtask

  task automatic run_init(input logic t, input logic r, input logic [1:0] m);
    wr(1'b1, t, r, m);
    @(negedge clk);
  endtask

  task automatic ack();
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  task automatic sreset();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "init", {31'd0, init_flag}, 0);
    chk("R1", "addr", {30'd0, byte_addr}, 0);
    chk("R1", "flags", flg(), 0);
    chk("R1", "err", {31'd0, init_err}, 0);
  endtask

  task automatic t_init_timing();
    wr(1'b1, 1'b0, 1'b0, 2'b00);
    chk("R2", "init after write", {31'd0, init_flag}, 1);
    @(negedge clk);
    chk("R2", "init self-cleared", {31'd0, init_flag}, 0);
    @(negedge clk);
    chk("R2", "init stays 0", {31'd0, init_flag}, 0);
  endtask

  task automatic t_no_enables();
    sreset();
    run_init(1'b1, 1'b0, 2'b01);
    ack();
    chk("R4", "setup addr", {30'd0, byte_addr}, 2);
    run_init(1'b0, 1'b0, 2'b11);
    chk("R4", "flags unchanged", flg(), 4'b0100);
    chk("R4", "addr loaded", {30'd0, byte_addr}, 3);
  endtask

  task automatic t_rx_dir();
    sreset();
    run_init(1'b0, 1'b1, 2'b01);
    chk("R5", "rx prep flags", flg(), 4'b0001);
    chk("R8", "addr mode01", {30'd0, byte_addr}, 1);
    ack();
    chk("R9", "addr step 2", {30'd0, byte_addr}, 2);
    ack();
    chk("R9", "addr step 3", {30'd0, byte_addr}, 3);
    chk("R13", "no early word done", flg(), 4'b0001);
    ack();
    chk("R9", "reload 1", {30'd0, byte_addr}, 1);
    chk("R13", "rx word done", flg(), 4'b1000);
    run_init(1'b0, 1'b1, 2'b01);
    chk("R5", "rx re-prep clears full", flg(), 4'b0001);
  endtask

  task automatic t_tx_dir();
    sreset();
    run_init(1'b1, 1'b0, 2'b10);
    chk("R6", "tx prep flags", flg(), 4'b0100);
    chk("R8", "addr mode10", {30'd0, byte_addr}, 2);
    ack();
    chk("R9", "addr step 3", {30'd0, byte_addr}, 3);
    ack();
    chk("R9", "reload 2", {30'd0, byte_addr}, 2);
    chk("R13", "tx word done", flg(), 4'b0010);
    run_init(1'b1, 1'b0, 2'b10);
    chk("R6", "tx re-prep clears host full", flg(), 4'b0100);
  endtask

  task automatic t_both_int();
    sreset();
    run_init(1'b1, 1'b1, 2'b00);
    chk("R7", "both dirs", flg(), 4'b0101);
    chk("R7", "addr 00", {30'd0, byte_addr}, 0);
    chk("R7", "no err", {31'd0, init_err}, 0);
    ack();
    ack();
    chk("R10", "int ack addr", {30'd0, byte_addr}, 0);
    chk("R10", "int ack flags", flg(), 4'b0101);
  endtask

  task automatic t_illegal();
    sreset();
    run_init(1'b1, 1'b0, 2'b01);
    ack();
    wr(1'b1, 1'b1, 1'b1, 2'b11);
    chk("R11", "err before run", {31'd0, init_err}, 0);
    @(negedge clk);
    chk("R11", "err raised", {31'd0, init_err}, 1);
    chk("R11", "flags unchanged", flg(), 4'b0100);
    chk("R11", "addr loaded", {30'd0, byte_addr}, 3);
    @(negedge clk);
    chk("R11", "err one cycle", {31'd0, init_err}, 0);
  endtask

  task automatic t_one_byte();
    sreset();
    run_init(1'b0, 1'b1, 2'b11);
    chk("R8", "addr mode11", {30'd0, byte_addr}, 3);
    ack();
    chk("R9", "reload 3", {30'd0, byte_addr}, 3);
    chk("R13", "one byte word done", flg(), 4'b1000);
  endtask

  task automatic t_stop();
    sreset();
    stop_req = 1'b1;
    wr(1'b1, 1'b1, 1'b0, 2'b01);
    stop_req = 1'b0;
    chk("R3", "stop blocks init", {31'd0, init_flag}, 0);
    @(negedge clk);
    chk("R3", "stop no command", flg(), 0);
    port_rst = 1'b1;
    wr(1'b1, 1'b1, 1'b0, 2'b01);
    port_rst = 1'b0;
    chk("R3", "port reset blocks init", {31'd0, init_flag}, 0);
  endtask

  task automatic t_reset_wins();
    sreset();
    run_init(1'b1, 1'b0, 2'b01);
    ack();
    wr(1'b1, 1'b1, 1'b0, 2'b10);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R12", "flags reset", flg(), 0);
    chk("R12", "addr reset", {30'd0, byte_addr}, 0);
    chk("R12", "init cleared", {31'd0, init_flag}, 0);
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; port_rst = 1'b0; stop_req = 1'b0;
    ctl_wr = 1'b0; ctl_init = 1'b0; ctl_treq = 1'b0; ctl_rreq = 1'b0;
    ctl_mode = '0; dma_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_timing();
    t_no_enables();
    t_rx_dir();
    t_tx_dir();
    t_both_int();
    t_illegal();
    t_one_byte();
    t_stop();
    t_reset_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule